// File: doc/BRIEF.md
# Convergent Rounding Word Reducer

This block narrows a wide signed two's-complement sample, such as the full-precision result of a filter accumulator, to a signed output word. The lowest `DROP_W` bits of the input are taken as a binary fraction below the kept integer part. The integer part is rounded to the nearest value. When the fraction is exactly one half, the result goes to the even neighbour, so ties split evenly between rounding up and rounding down and leave no average offset.

A two-bit mode input, sampled along with every sample, can select plain truncation or round-half-up instead of the default behaviour. These modes exist so that the bias of each method can be measured against the default. A rounded result outside the output range is clamped to the largest or smallest representable value. Each sample taken with `in_valid` appears, rounded, one clock later with `out_valid`.

Top module: `conv_round_reducer`

## Requirements
- R1: While `rst` is high and in the cycle after it, `out_valid` is 0 and `out_data` is 0.
- R2: `out_valid` equals `in_valid` of the previous cycle, and a sample taken with `in_valid` high appears on `out_data` exactly one clock later.
- R3: In mode 0 (convergent) a fraction below one half rounds down and a fraction above one half rounds up (toward +infinity by one step).
- R4: In mode 0 a fraction of exactly one half (top dropped bit 1, all other dropped bits 0) rounds up only when the kept LSB is 1, so the result is even.
- R5: In mode 1 (truncate) the dropped bits are discarded and the result is the floor of the input value.
- R6: In mode 2 (round half up) the result is incremented whenever the top dropped bit is 1, whatever the other dropped bits are.
- R7: A rounded value above the largest output value, including one that overflows only through the rounding increment, gives +32767 (for `OUT_W` = 16).
- R8: A kept value below the smallest output value gives -32768 (for `OUT_W` = 16).
- R9: Mode code 3 behaves exactly as mode 0.
- R10: In a cycle with `in_valid` low, `out_data` keeps its value in the next cycle.
- R11: Over a symmetric sweep of exact-half inputs, the average signed error is zero in mode 0, negative in mode 1 and positive in mode 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample is present this cycle |
| in_data | input | IN_W | Wide signed input sample |
| in_mode | input | 2 | Rounding mode: 0 convergent, 1 truncate, 2 half up, 3 as 0 |
| out_valid | output | 1 | Rounded word is present this cycle |
| out_data | output | OUT_W | Rounded, saturated signed word |

## Verification
The rounding increment and the positive clamp can meet in a single sample: a kept value of +32767 with an exact-half fraction is odd, so convergent rounding carries it past the range and the clamp has to catch it. Directed samples place exact halves on both sides of that edge (32766 stays, 32767 clamps) and just under -32768, where an above-half fraction brings a value back into range. Each result is compared against a bench model that computes the rounding and the clamp separately in 64-bit arithmetic.

// File: rtl/rnd_pkg.sv
package rnd_pkg;
  typedef enum logic [1:0] {
    RM_CONV   = 2'd0,
    RM_TRUNC  = 2'd1,
    RM_HALFUP = 2'd2,
    RM_RSVD   = 2'd3
  } rnd_mode_e;
endpackage

// File: rtl/rnd_decide.sv
// Decides whether the kept integer part is incremented, from the dropped
// fraction, the kept LSB and the selected mode.
module rnd_decide #(
  parameter int DROP_W = 12
) (
  input  logic [1:0]        mode,
  input  logic              kept_lsb,
  input  logic [DROP_W-1:0] frac,
  output logic              inc
);
  import rnd_pkg::*;

  logic half_bit;
  logic tail_nz;

  assign half_bit = frac[DROP_W-1];

  generate
    if (DROP_W > 1) begin : g_tail
      assign tail_nz = |frac[DROP_W-2:0];
    end else begin : g_notail
      assign tail_nz = 1'b0;
    end
  endgenerate

  always_comb begin
    unique case (rnd_mode_e'(mode))
      RM_TRUNC:  inc = 1'b0;
      RM_HALFUP: inc = half_bit;
      default:   inc = half_bit & (tail_nz | kept_lsb);
    endcase
  end
endmodule

// File: rtl/rnd_sat.sv
// Adds the increment to the kept part and clamps into the output range.
module rnd_sat #(
  parameter int KEEP_W = 28,
  parameter int OUT_W  = 16
) (
  input  logic [KEEP_W-1:0] kept,
  input  logic              inc,
  output logic [OUT_W-1:0]  word
);
  localparam int SUM_W = KEEP_W + 1;
  localparam logic signed [SUM_W-1:0] HI_S = SUM_W'((longint'(1) <<< (OUT_W-1)) - 1);
  localparam logic signed [SUM_W-1:0] LO_S = -HI_S - SUM_W'(1);
  localparam logic [OUT_W-1:0] HI_W = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] LO_W = {1'b1, {(OUT_W-1){1'b0}}};

  logic signed [SUM_W-1:0] sum;

  assign sum = $signed({kept[KEEP_W-1], kept}) + $signed({{KEEP_W{1'b0}}, inc});

  always_comb begin
    if (sum > HI_S)      word = HI_W;
    else if (sum < LO_S) word = LO_W;
    else                 word = sum[OUT_W-1:0];
  end
endmodule

// File: rtl/conv_round_reducer.sv
module conv_round_reducer #(
  parameter int IN_W   = 40,
  parameter int DROP_W = 12,
  parameter int OUT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [IN_W-1:0]   in_data,
  input  logic [1:0]        in_mode,
  output logic              out_valid,
  output logic [OUT_W-1:0]  out_data
);
  localparam int KEEP_W = IN_W - DROP_W;

  logic [KEEP_W-1:0] kept;
  logic [DROP_W-1:0] frac;
  logic              inc;
  logic [OUT_W-1:0]  word;

  assign kept = in_data[IN_W-1:DROP_W];
  assign frac = in_data[DROP_W-1:0];

  rnd_decide #(.DROP_W(DROP_W)) u_dec (
    .mode     (in_mode),
    .kept_lsb (kept[0]),
    .frac     (frac),
    .inc      (inc)
  );

  rnd_sat #(.KEEP_W(KEEP_W), .OUT_W(OUT_W)) u_sat (
    .kept (kept),
    .inc  (inc),
    .word (word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= word;
    end
  end
endmodule

// File: rtl/round_chk.sv
module round_chk #(
  parameter int IN_W   = 40,
  parameter int DROP_W = 12,
  parameter int OUT_W  = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [IN_W-1:0]  in_data,
  input logic [1:0]       in_mode,
  input logic             out_valid,
  input logic [OUT_W-1:0] out_data
);
  localparam int KEEP_W = IN_W - DROP_W;
  localparam logic signed [KEEP_W-1:0] HI_K = KEEP_W'((longint'(1) <<< (OUT_W-1)) - 1);
  localparam logic signed [KEEP_W-1:0] LO_K = -HI_K - KEEP_W'(1);
  localparam logic [OUT_W-1:0] HI_W = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] LO_W = {1'b1, {(OUT_W-1){1'b0}}};
  localparam logic [DROP_W-1:0] HALF = {1'b1, {(DROP_W-1){1'b0}}};

  logic signed [KEEP_W-1:0] kept_s;
  logic exact_half;
  logic fits_below_top;
  logic fits;

  assign kept_s         = $signed(in_data[IN_W-1:DROP_W]);
  assign exact_half     = (in_data[DROP_W-1:0] == HALF);
  assign fits_below_top = (kept_s >= LO_K) && (kept_s < HI_K);
  assign fits           = (kept_s >= LO_K) && (kept_s <= HI_K);

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  // R2
  valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R10
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_data));
  // R4
  tie_even_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_mode == 2'd0 && exact_half && fits_below_top) |=> !out_data[0]);
  // R5
  trunc_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_mode == 2'd1 && fits) |=> out_data == $past(in_data[DROP_W+OUT_W-1:DROP_W]));
  // R7
  sat_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && kept_s > HI_K) |=> out_data == HI_W);
  // R8
  sat_lo_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && kept_s < LO_K) |=> out_data == LO_W);
endmodule

bind conv_round_reducer round_chk #(.IN_W(IN_W), .DROP_W(DROP_W), .OUT_W(OUT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_data   (in_data),
  .in_mode   (in_mode),
  .out_valid (out_valid),
  .out_data  (out_data)
);

// File: tb/sim_conv_round_reducer.sv
module sim_conv_round_reducer;
  localparam int CLK_PERIOD = 10;
  localparam int IN_W   = 40;
  localparam int DROP_W = 12;
  localparam int OUT_W  = 16;
  localparam longint HALF = longint'(1) <<< (DROP_W-1);
  localparam longint FMASK = (longint'(1) <<< DROP_W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [IN_W-1:0] in_data = '0;
  logic [1:0] in_mode = 2'd0;
  logic out_valid;
  logic [OUT_W-1:0] out_data;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  conv_round_reducer #(.IN_W(IN_W), .DROP_W(DROP_W), .OUT_W(OUT_W)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_mode(in_mode), .out_valid(out_valid), .out_data(out_data)
  );

  function automatic longint ref_round(longint v, int mode);
    longint k, f, r;
    k = v >>> DROP_W;
    f = v & FMASK;
    case (mode)
      1: r = k;
      2: r = (f >= HALF) ? k + 1 : k;
      default: begin
        if (f > HALF) r = k + 1;
        else if (f < HALF) r = k;
        else r = ((k & 1) != 0) ? k + 1 : k;
      end
    endcase
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return r;
  endfunction

  function automatic longint mk(longint k, longint f);
    return (k <<< DROP_W) + f;
  endfunction

  function automatic longint outv();
    return longint'($signed(out_data));
  endfunction

  task automatic chk(string req, longint act, longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive one sample at a falling edge, check it at the next falling edge
  task automatic one(string req, longint v, int mode);
    in_data  = v[IN_W-1:0];
    in_mode  = 2'(mode);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(req, outv(), ref_round(v, mode));
  endtask

  initial begin
    longint sum_err;
    longint last;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 valid", longint'(out_valid), 0);
    chk("R1 data", outv(), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after release", longint'(out_valid), 0);

    // R2: latency and valid
    in_data = mk(100, 0)[IN_W-1:0]; in_mode = 2'd0; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R2 valid", longint'(out_valid), 1);
    chk("R2 data", outv(), 100);
    @(negedge clk);
    chk("R2 valid drop", longint'(out_valid), 0);

    // R3: nearest in convergent mode
    one("R3 below", mk(7, HALF - 1), 0);
    one("R3 above", mk(7, HALF + 1), 0);
    one("R3 neg above", mk(-8, HALF + 3), 0);
    // R4: ties to even
    one("R4 1.5", mk(1, HALF), 0);
    chk("R4 1.5 val", outv(), 2);
    one("R4 2.5", mk(2, HALF), 0);
    chk("R4 2.5 val", outv(), 2);
    one("R4 -1.5", mk(-2, HALF), 0);
    chk("R4 -1.5 val", outv(), -2);
    // R5: truncate
    one("R5 pos", mk(9, FMASK), 1);
    one("R5 neg", mk(-9, 1), 1);
    // R6: half up
    one("R6 tie even", mk(2, HALF), 2);
    chk("R6 tie val", outv(), 3);
    one("R6 below", mk(2, HALF - 1), 2);
    // R7: saturation high, including carry from rounding
    one("R7 tie 32766", mk(32766, HALF), 0);
    chk("R7 32766 val", outv(), 32766);
    one("R7 tie 32767", mk(32767, HALF), 0);
    chk("R7 carry clamp", outv(), 32767);
    one("R7 big", mk(100000, 5), 1);
    // R8: saturation low
    one("R8 trunc", mk(-32769, 5), 1);
    chk("R8 val", outv(), -32768);
    one("R8 back in range", mk(-32769, HALF + 1), 0);
    chk("R8 rounded in", outv(), -32768);
    one("R8 deep", mk(-900000, 0), 2);
    // R9: code 3 as convergent
    one("R9 tie odd", mk(3, HALF), 3);
    chk("R9 tie val", outv(), 4);
    one("R9 tie even", mk(4, HALF), 3);

    // R10: hold when idle
    last = outv();
    in_data = mk(-500, 7)[IN_W-1:0]; in_mode = 2'd2;
    repeat (2) @(negedge clk);
    chk("R10 hold", outv(), last);
    chk("R10 valid", longint'(out_valid), 0);

    // R11: bias over a symmetric sweep of exact halves
    for (int m = 0; m < 3; m++) begin
      sum_err = 0;
      for (int k = -50; k < 50; k++) begin
        one("R11 sweep", mk(k, HALF), m);
        sum_err += (outv() <<< DROP_W) - mk(k, HALF);
      end
      if (m == 0) chk("R11 conv zero", sum_err, 0);
      if (m == 1) chk("R11 trunc neg", longint'(sum_err < 0), 1);
      if (m == 2) chk("R11 halfup pos", longint'(sum_err > 0), 1);
    end

    // back-to-back random samples, R2 R3 R5 R6 R7 R8
    begin
      longint prev;
      int pmode;
      bit have;
      have = 1'b0;
      prev = 0;
      pmode = 0;
      for (int i = 0; i < 2000; i++) begin
        longint k, f, v;
        int m;
        k = longint'($urandom_range(0, 90000)) - 45000;
        case ($urandom_range(0, 3))
          0: f = HALF;
          1: f = 0;
          default: f = longint'($urandom_range(0, 32'(FMASK)));
        endcase
        v = mk(k, f);
        m = int'($urandom_range(0, 3));
        in_data = v[IN_W-1:0]; in_mode = 2'(m); in_valid = 1'b1;
        @(negedge clk);
        chk("R2 stream valid", longint'(out_valid), 1);
        chk("R3 R7 R8 stream", outv(), ref_round(v, m));
        prev = v; pmode = m; have = 1'b1;
      end
      in_valid = 1'b0;
    end
    @(negedge clk);
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule